// File: doc/BRIEF.md
# PLL Reference-Loss Monitor

This block watches the reference clock of a phase-locked loop and reports when that reference stops toggling. All of its logic runs on a clock derived from the VCO, so it can only detect a loss while the VCO is running. The reference is an asynchronous input. It is brought into the VCO domain through a two-flop synchronizer, and its rising edges are extracted there.

Detection does not start at once. The monitor arms only after the digital lock-detect input has stayed high for a selectable number of phase-detector cycles, and it counts those cycles from a one-cycle tick input. Once armed, the monitor times the gap between reference edges. If the gap exceeds a fixed budget of VCO cycles, it raises a sticky loss flag and a charge-pump tri-state request in the same cycle. The lock-detect input plays no part in deciding whether the reference is present, because lock detect can stay high after the reference has gone.

Software recovers by driving the enable input low, which clears both outputs and stops detection, and then high again, which starts a fresh arming wait. A 4-bit select drives one status output. It can show the loss flag, or the flag OR'd with loss of lock, in either polarity.

Top module: `refloss_monitor`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `ref_lost` and `cp_tristate` are 0, and `stat_out` is 0 for select code 0000.
- R2: The arming wait is selected by `arm_sel`: 00 gives 3 ticks, 01 gives 6, 10 gives 12 and 11 gives 24 consecutive `pfd_tick` pulses with `lock_det` high. Before the wait completes, a missing reference never sets the flag.
- R3: If `lock_det` goes low before the arming wait completes, the tick count restarts from zero.
- R4: Once armed, if no rising reference edge arrives within TIMEOUT_CYC VCO cycles, `ref_lost` and `cp_tristate` both go to 1 in the same cycle.
- R5: While armed, reference rising edges spaced closer than TIMEOUT_CYC cycles keep `ref_lost` at 0.
- R6: `ref_lost` and `cp_tristate` are sticky. They stay at 1 when the reference returns or `lock_det` changes, for as long as `mon_en` stays 1.
- R7: When `mon_en` is 0, both outputs are 0 from the next cycle on and detection is disabled. After `mon_en` returns to 1, a full new arming wait is required.
- R8: The flag is set by a missing reference even while `lock_det` stays high.
- R9: `stat_sel` = 1010 drives `stat_out` = `ref_lost`, and 1111 drives `stat_out` = NOT `ref_lost`.
- R10: `stat_sel` = 1101 drives `stat_out` = (NOT `lock_det`) OR `ref_lost`, and 1110 drives the inverse of that value.
- R11: Every other `stat_sel` code drives `stat_out` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | VCO-derived clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_in | input | 1 | Reference clock, asynchronous to clk |
| pfd_tick | input | 1 | One-cycle pulse per phase-detector cycle |
| lock_det | input | 1 | Digital lock detect, synchronous to clk |
| mon_en | input | 1 | Monitor enable; writing 0 then 1 clears and re-arms |
| arm_sel | input | 2 | Arming-wait select (3/6/12/24 ticks) |
| stat_sel | input | 4 | Status output select code |
| ref_lost | output | 1 | Sticky loss-of-reference flag |
| cp_tristate | output | 1 | Charge-pump tri-state request |
| stat_out | output | 1 | Selected status signal |

## Verification
The bench builds the monitor with TIMEOUT_CYC set to 16 instead of the default 64. It spaces its phase-detector ticks 32 clocks apart, so each timeout window closes well before the next tick arrives. The exact tick that arms the monitor is then visible at the flag: the bench checks the flag low after one tick fewer than the wait and high after the last one, for all four arming codes. The bench toggles the reference every 4 clocks, which gives a rising edge every 8 clocks, inside the 16-cycle budget. This lets it check that the flag stays low while the reference is present and rises shortly after the reference stops.

// File: rtl/refloss_pkg.sv
package refloss_pkg;

    localparam int ARM_CW = 5;

    localparam logic [3:0] SEL_LOR_HI = 4'b1010;
    localparam logic [3:0] SEL_LOR_LO = 4'b1111;
    localparam logic [3:0] SEL_ANY_HI = 4'b1101;
    localparam logic [3:0] SEL_ANY_LO = 4'b1110;

    // 00->3, 01->6, 10->12, 11->24 phase-detector cycles
    function automatic logic [ARM_CW-1:0] arm_target(input logic [1:0] sel);
        return ARM_CW'(3) << sel;
    endfunction

endpackage

// File: rtl/refloss_edge.sv
module refloss_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    localparam int DEPTH = STAGES + 1;

    logic [DEPTH-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[DEPTH-2:0], async_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];

endmodule

// File: rtl/refloss_arm.sv
module refloss_arm
    import refloss_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mon_en,
    input  logic       lock_det,
    input  logic       pfd_tick,
    input  logic [1:0] arm_sel,
    output logic       armed
);
    typedef struct packed {
        logic [ARM_CW-1:0] cnt;
        logic              armed;
    } arm_st_t;

    arm_st_t st_d, st_q;
    logic [ARM_CW-1:0] tgt;

    assign tgt = arm_target(arm_sel);

    always_comb begin
        st_d = st_q;
        if (!mon_en || (!lock_det && !st_q.armed)) begin
            st_d = '0;
        end else if (pfd_tick && !st_q.armed) begin
            if (st_q.cnt + ARM_CW'(1) >= tgt) begin
                st_d.armed = 1'b1;
                st_d.cnt   = tgt;
            end else begin
                st_d.cnt = st_q.cnt + ARM_CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign armed = st_q.armed;

    AST_DISARM_ON_EN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !mon_en |=> !st_q.armed); // R7
    AST_LOCK_DROP_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (!lock_det && !st_q.armed) |=> (st_q.cnt == '0)); // R3
    AST_ARM_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.armed) |-> $past(pfd_tick && lock_det)); // R2

endmodule

// File: rtl/refloss_watch.sv
module refloss_watch #(
    parameter int TIMEOUT_CYC = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mon_en,
    input  logic armed,
    input  logic ref_rise,
    output logic flag,
    output logic cp_tri
);
    localparam int TW = $clog2(TIMEOUT_CYC + 1);
    localparam logic [TW-1:0] LIMIT = TW'(TIMEOUT_CYC - 1);

    typedef struct packed {
        logic [TW-1:0] tmr;
        logic          flag;
        logic          cp;
    } watch_st_t;

    watch_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!mon_en) begin
            st_d = '0;
        end else begin
            if (!armed || ref_rise)  st_d.tmr = '0;
            else if (st_q.tmr != LIMIT) st_d.tmr = st_q.tmr + TW'(1);
            if (armed && !ref_rise && st_q.tmr == LIMIT) begin
                st_d.flag = 1'b1;
                st_d.cp   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag   = st_q.flag;
    assign cp_tri = st_q.cp;

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.flag && mon_en) |=> st_q.flag); // R6
    AST_CLEAR_ON_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !mon_en |=> (!st_q.flag && !st_q.cp)); // R7
    AST_SET_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.flag) |-> $past(armed)); // R2
    AST_CP_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.flag) |-> $rose(st_q.cp)); // R4

endmodule

// File: rtl/refloss_status.sv
module refloss_status
    import refloss_pkg::*;
(
    input  logic [3:0] stat_sel,
    input  logic       flag,
    input  logic       lock_det,
    output logic       stat_out
);
    logic any_loss;

    always_comb begin
        any_loss = ~lock_det | flag;
        case (stat_sel)
            SEL_LOR_HI: stat_out = flag;
            SEL_LOR_LO: stat_out = ~flag;
            SEL_ANY_HI: stat_out = any_loss;
            SEL_ANY_LO: stat_out = ~any_loss;
            default:    stat_out = 1'b0;
        endcase
    end

endmodule

// File: rtl/refloss_monitor.sv
module refloss_monitor #(
    parameter int TIMEOUT_CYC = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ref_in,
    input  logic       pfd_tick,
    input  logic       lock_det,
    input  logic       mon_en,
    input  logic [1:0] arm_sel,
    input  logic [3:0] stat_sel,
    output logic       ref_lost,
    output logic       cp_tristate,
    output logic       stat_out
);
    logic ref_rise;
    logic armed;

    refloss_edge #(.STAGES(SYNC_STAGES)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (ref_in),
        .rise     (ref_rise)
    );

    refloss_arm u_arm (
        .clk      (clk),
        .rst_n    (rst_n),
        .mon_en   (mon_en),
        .lock_det (lock_det),
        .pfd_tick (pfd_tick),
        .arm_sel  (arm_sel),
        .armed    (armed)
    );

    refloss_watch #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_watch (
        .clk      (clk),
        .rst_n    (rst_n),
        .mon_en   (mon_en),
        .armed    (armed),
        .ref_rise (ref_rise),
        .flag     (ref_lost),
        .cp_tri   (cp_tristate)
    );

    refloss_status u_stat (
        .stat_sel (stat_sel),
        .flag     (ref_lost),
        .lock_det (lock_det),
        .stat_out (stat_out)
    );

endmodule

// File: tb/sim_refloss_monitor.sv
module sim_refloss_monitor;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_in = 1'b0;
    logic       pfd_tick = 1'b0;
    logic       lock_det = 1'b0;
    logic       mon_en = 1'b0;
    logic [1:0] arm_sel = 2'b00;
    logic [3:0] stat_sel = 4'b0000;
    logic       ref_lost, cp_tristate, stat_out;
    logic       ref_run = 1'b0;
    logic       done = 1'b0;
    int         checks = 0;
    int         errors = 0;

    always #4 clk = ~clk;

    refloss_monitor #(.TIMEOUT_CYC(16)) u0 (
        .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .pfd_tick(pfd_tick),
        .lock_det(lock_det), .mon_en(mon_en), .arm_sel(arm_sel),
        .stat_sel(stat_sel), .ref_lost(ref_lost), .cp_tristate(cp_tristate),
        .stat_out(stat_out)
    );

    initial forever begin
        repeat (4) @(negedge clk);
        if (ref_run) ref_in = ~ref_in;
    end

    typedef struct packed { logic [1:0] sel; int ticks; } arm_vec_t;
    localparam arm_vec_t ARM_TAB [4] = '{
        '{2'b00, 3}, '{2'b01, 6}, '{2'b10, 12}, '{2'b11, 24}
    };

    typedef struct packed { logic [3:0] sel; logic lock; logic exp_f0; logic exp_f1; } st_vec_t;
    localparam st_vec_t ST_TAB [9] = '{
        '{4'b1010, 1'b1, 1'b0, 1'b1},
        '{4'b1111, 1'b1, 1'b1, 1'b0},
        '{4'b1101, 1'b1, 1'b0, 1'b1},
        '{4'b1101, 1'b0, 1'b1, 1'b1},
        '{4'b1110, 1'b1, 1'b1, 1'b0},
        '{4'b1110, 1'b0, 1'b0, 1'b0},
        '{4'b0000, 1'b0, 1'b0, 1'b0},
        '{4'b0101, 1'b0, 1'b0, 1'b0},
        '{4'b1011, 1'b1, 1'b0, 1'b0}
    };

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic tick();
        @(negedge clk) pfd_tick = 1'b1;
        @(negedge clk) pfd_tick = 1'b0;
    endtask

    task automatic restart();
        mon_en = 1'b0;
        cyc(2);
        mon_en = 1'b1;
    endtask

    function automatic string st_req(input logic [3:0] s);
        if (s == 4'b1010 || s == 4'b1111) return "R9";
        if (s == 4'b1101 || s == 4'b1110) return "R10";
        return "R11";
    endfunction

    task automatic walk_status(input logic flag_now);
        for (int i = 0; i < 9; i++) begin
            @(negedge clk);
            stat_sel = ST_TAB[i].sel;
            lock_det = ST_TAB[i].lock;
            #1;
            chk(st_req(ST_TAB[i].sel), stat_out,
                flag_now ? ST_TAB[i].exp_f1 : ST_TAB[i].exp_f0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        cyc(3);
        chk("R1", ref_lost, 1'b0);
        chk("R1", cp_tristate, 1'b0);
        chk("R1", stat_out, 1'b0);
        rst_n = 1'b1;
        cyc(1);
        chk("R1", ref_lost, 1'b0);

        // R2 / R4 / R8: arming wait per select code, reference stopped, lock high
        for (int i = 0; i < 4; i++) begin
            mon_en = 1'b0;
            ref_run = 1'b0;
            lock_det = 1'b1;
            arm_sel = ARM_TAB[i].sel;
            cyc(2);
            mon_en = 1'b1;
            for (int k = 1; k < ARM_TAB[i].ticks; k++) begin
                tick();
                cyc(30);
            end
            chk("R2", ref_lost, 1'b0);
            tick();
            cyc(20);
            chk("R2", ref_lost, 1'b1);
            chk("R4", cp_tristate, 1'b1);
            chk("R8", lock_det, 1'b1);
        end

        // R6 sticky: reference back, lock toggles
        ref_run = 1'b1;
        lock_det = 1'b0;
        cyc(40);
        lock_det = 1'b1;
        cyc(20);
        chk("R6", ref_lost, 1'b1);
        chk("R6", cp_tristate, 1'b1);

        // R9/R10/R11 with flag high
        walk_status(1'b1);

        // R7 clear on disable
        @(negedge clk) mon_en = 1'b0;
        cyc(1);
        chk("R7", ref_lost, 1'b0);
        chk("R7", cp_tristate, 1'b0);

        // R9/R10/R11 with flag low
        walk_status(1'b0);

        // R7 disabled: no detection
        ref_run = 1'b0;
        lock_det = 1'b1;
        arm_sel = 2'b00;
        for (int k = 0; k < 4; k++) begin tick(); cyc(10); end
        cyc(40);
        chk("R7", ref_lost, 1'b0);

        // R3 lock drop restarts count (3-tick wait)
        mon_en = 1'b1;
        tick(); cyc(30);
        tick(); cyc(30);
        lock_det = 1'b0;
        cyc(1);
        lock_det = 1'b1;
        tick(); cyc(30);
        tick(); cyc(20);
        chk("R3", ref_lost, 1'b0);
        tick(); cyc(20);
        chk("R3", ref_lost, 1'b1);

        // R7 re-enable needs full arming wait
        restart();
        tick(); cyc(30);
        tick(); cyc(20);
        chk("R7", ref_lost, 1'b0);

        // R5 reference present keeps flag low
        restart();
        ref_run = 1'b1;
        for (int k = 0; k < 3; k++) begin tick(); cyc(20); end
        cyc(200);
        chk("R5", ref_lost, 1'b0);
        ref_run = 1'b0;
        cyc(30);
        chk("R5", ref_lost, 1'b1);

        // R1 reset while flagged
        rst_n = 1'b0;
        cyc(1);
        chk("R1", ref_lost, 1'b0);
        chk("R1", cp_tristate, 1'b0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule